// File: doc/BRIEF.md
# Shared Work-RAM Bank Mapper

This block is a byte-addressable work memory shared by two requesters, side A and side B, each with its own address, read strobe, write strobe, access size and data buses. A two-bit mapping mode decides how the storage is split between the two sides. One side can own the whole window with the other cut off. Each side can own one half of the storage, seen repeated over its whole window. The two halves can also be swapped between the sides. The mode is loaded at run time, so software can hand memory from one processor to the other without copying.

Each side's address is cut down to the window width. It is then aligned to the access size and translated through a per-side table of page entries. The tables are rebuilt from the new mode in the same edge that loads the mode. A side that has no mapping reads zero and has its writes dropped. It also gets a one-cycle error pulse. Read data comes back one cycle after the request.

The window size `WIN_BYTES` and the page size `PAGE_BYTES` are parameters. The 32 KiB configuration uses `WIN_BYTES = 32768`, which gives a 15-bit address mask and 32 page entries of 1 KiB per side. The defaults keep the same structure at a smaller size. In the requirements, H stands for `WIN_BYTES/2`.

Top module: `shared_wram_mapper`

## Requirements
- R1: Address bits at and above log2(WIN_BYTES) are ignored. Two addresses that differ only there reach the same byte.
- R2: In mode 2'b00, side A sees all WIN_BYTES linearly, and side B is unmapped.
- R3: In mode 2'b01, a side A address m (after masking) reaches physical H + (m mod H). A side B address m reaches physical m mod H. Each view therefore repeats across the window, and neither side raises an error.
- R4: In mode 2'b10 the halves are swapped: side A reaches m mod H, and side B reaches H + (m mod H). Neither side raises an error.
- R5: In mode 2'b11, side B sees all WIN_BYTES linearly, and side A is unmapped.
- R6: An access on an unmapped side reads 32'h0 and discards its write data. It also drives that side's err high for exactly the one cycle after the request.
- R7: The size code selects the access width: 2'b00 for a byte, 2'b01 for a halfword, and 2'b10 or 2'b11 for a word. The low address bits are cleared to the size's alignment. Data is little-endian in the word. Write data is taken from the low bits of wdata, and read data is returned zero-extended.
- R8: The mode resets to 2'b00. A mode load takes effect from the cycle after mode_we. Accesses made in the same cycle as mode_we still use the old mapping.
- R9: rdata is valid in the cycle after a read. It is 32'h0 in any cycle that does not follow a mapped read. A read sees the memory contents from before any write in the same cycle.
- R10: When rd and wr are both high on one side, the write is performed and no read is made, so rdata is 32'h0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we | input | 1 | Load the mapping mode |
| mode_wdata | input | 2 | New mapping mode |
| a_rd | input | 1 | Side A read strobe |
| a_wr | input | 1 | Side A write strobe |
| a_size | input | 2 | Side A access size |
| a_addr | input | ADDR_W | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, one cycle after the request |
| a_err | output | 1 | Side A unmapped-access pulse |
| b_rd | input | 1 | Side B read strobe |
| b_wr | input | 1 | Side B write strobe |
| b_size | input | 2 | Side B access size |
| b_addr | input | ADDR_W | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, one cycle after the request |
| b_err | output | 1 | Side B unmapped-access pulse |

## Verification
A corrupt page entry shows up on the first access that uses that page. The read returns the other half's data, or the same data again at the wrong repeat. The access may also raise a false error pulse or miss a real one. Any of these is visible one cycle after the request. A mode register or table that loads a cycle early or late shows at the very next access: the bench drives reads and writes in the same cycle as the mode load and checks them against the old mapping. Lane or alignment faults show as shifted or unmasked bytes in the read that follows a narrow write.

// File: rtl/wram_map_pkg.sv
package wram_map_pkg;

   typedef enum logic [1:0] {
      ACC_BYTE     = 2'b00,
      ACC_HALF     = 2'b01,
      ACC_WORD     = 2'b10,
      ACC_WORD_ALT = 2'b11
   } acc_size_e;

   typedef enum logic [1:0] {
      MAP_A_ALL     = 2'b00,
      MAP_A_HI_B_LO = 2'b01,
      MAP_A_LO_B_HI = 2'b10,
      MAP_B_ALL     = 2'b11
   } map_mode_e;

   // Low address bits cleared by alignment for each access size.
   function automatic logic [1:0] size_low_mask(acc_size_e s);
      case (s)
         ACC_BYTE: return 2'b00;
         ACC_HALF: return 2'b01;
         default:  return 2'b11;
      endcase
   endfunction

   // Byte-lane enables for an aligned access at the given lane.
   function automatic logic [3:0] lane_enables(acc_size_e s, logic [1:0] lane);
      case (s)
         ACC_BYTE: return 4'b0001 << lane;
         ACC_HALF: return 4'b0011 << lane;
         default:  return 4'b1111;
      endcase
   endfunction

endpackage

// File: rtl/wram_page_table.sv
module wram_page_table
   import wram_map_pkg::*;
#(
   parameter int NUM_PAGES = 8,
   parameter bit SIDE_B    = 1'b0,
   parameter int PG_W      = $clog2(NUM_PAGES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  map_mode_e       new_mode,
   input  logic [PG_W-1:0] page_idx,
   output logic            hit,
   output logic [PG_W-1:0] phys_page
);

   localparam int HALF_PAGES = NUM_PAGES / 2;

   // Entry is {valid, physical page} for one logical page under a mode.
   function automatic logic [PG_W:0] entry_for(map_mode_e md, int unsigned idx);
      logic [PG_W-1:0] lin_pg;
      logic [PG_W-1:0] lo_pg;
      logic [PG_W-1:0] hi_pg;
      lin_pg = PG_W'(idx);
      lo_pg  = PG_W'(idx % HALF_PAGES);
      hi_pg  = PG_W'(HALF_PAGES + (idx % HALF_PAGES));
      case (md)
         MAP_A_ALL:     return SIDE_B ? {1'b0, lin_pg} : {1'b1, lin_pg};
         MAP_A_HI_B_LO: return SIDE_B ? {1'b1, lo_pg}  : {1'b1, hi_pg};
         MAP_A_LO_B_HI: return SIDE_B ? {1'b1, hi_pg}  : {1'b1, lo_pg};
         default:       return SIDE_B ? {1'b1, lin_pg} : {1'b0, lin_pg};
      endcase
   endfunction

   logic [PG_W:0] table_w [NUM_PAGES];

   for (genvar gi = 0; gi < NUM_PAGES; gi++) begin : g_entry
      logic [PG_W:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= entry_for(MAP_A_ALL, gi);
         end else if (load) begin
            ent_q <= entry_for(new_mode, gi);
         end
      end
      assign table_w[gi] = ent_q;
   end

   assign {hit, phys_page} = table_w[page_idx];

endmodule

// File: rtl/wram_port.sv
module wram_port
   import wram_map_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int WIN_AW  = 13,
   parameter int PAGE_AW = 10,
   parameter bit SIDE_B  = 1'b0,
   parameter int PG_W    = WIN_AW - PAGE_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_load,
   input  map_mode_e         map_new,
   input  logic              rd,
   input  logic              wr,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic [31:0]       mem_rword,
   output logic              mem_we,
   output logic              mem_re,
   output logic [WIN_AW-3:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   output logic [31:0]       rdata,
   output logic              err
);

   localparam int NUM_PAGES = 1 << PG_W;

   acc_size_e         sz;
   logic [WIN_AW-1:0] win_addr;
   logic [WIN_AW-1:0] algn_addr;
   logic [WIN_AW-1:0] phys_addr;
   logic              pg_hit;
   logic [PG_W-1:0]   pg_phys;
   logic [1:0]        lane;
   logic              acc;

   assign sz        = acc_size_e'(size);
   assign win_addr  = addr[WIN_AW-1:0];
   assign algn_addr = {win_addr[WIN_AW-1:2], win_addr[1:0] & ~size_low_mask(sz)};

   if (ADDR_W > WIN_AW) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:WIN_AW];
   end

   wram_page_table #(
      .NUM_PAGES(NUM_PAGES),
      .SIDE_B   (SIDE_B),
      .PG_W     (PG_W)
   ) i_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (map_load),
      .new_mode (map_new),
      .page_idx (algn_addr[WIN_AW-1:PAGE_AW]),
      .hit      (pg_hit),
      .phys_page(pg_phys)
   );

   assign phys_addr = {pg_phys, algn_addr[PAGE_AW-1:0]};
   assign mem_addr  = phys_addr[WIN_AW-1:2];
   assign lane      = phys_addr[1:0];
   assign mem_be    = lane_enables(sz, lane);

   always_comb begin
      case (sz)
         ACC_BYTE: mem_wdata = {4{wdata[7:0]}};
         ACC_HALF: mem_wdata = {2{wdata[15:0]}};
         default:  mem_wdata = wdata;
      endcase
   end

   assign acc    = rd | wr;
   assign mem_we = wr & pg_hit;
   assign mem_re = rd & ~wr & pg_hit;

   logic      err_q;
   logic      rv_q;
   logic [1:0] lane_q;
   acc_size_e size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         rv_q   <= 1'b0;
         lane_q <= 2'b00;
         size_q <= ACC_WORD;
      end else begin
         err_q  <= acc & ~pg_hit;
         rv_q   <= mem_re;
         lane_q <= lane;
         size_q <= sz;
      end
   end

   logic [31:0] shifted;
   assign shifted = mem_rword >> {lane_q, 3'b000};

   always_comb begin
      rdata = 32'd0;
      if (rv_q) begin
         case (size_q)
            ACC_BYTE: rdata = {24'd0, shifted[7:0]};
            ACC_HALF: rdata = {16'd0, shifted[15:0]};
            default:  rdata = shifted;
         endcase
      end
   end

   assign err = err_q;

endmodule

// File: rtl/wram_store.sv
module wram_store #(
   parameter int WORDS = 2048,
   parameter int WA    = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          a_we,
   input  logic          a_re,
   input  logic [WA-1:0] a_addr,
   input  logic [3:0]    a_be,
   input  logic [31:0]   a_wdata,
   output logic [31:0]   a_rword,
   input  logic          b_we,
   input  logic          b_re,
   input  logic [WA-1:0] b_addr,
   input  logic [3:0]    b_be,
   input  logic [31:0]   b_wdata,
   output logic [31:0]   b_rword
);

   logic [31:0] mem [WORDS];

   // Reads see pre-write contents; side A lanes are applied last and win.
   always_ff @(posedge clk) begin
      if (a_re) a_rword <= mem[a_addr];
      if (b_re) b_rword <= mem[b_addr];
      for (int k = 0; k < 4; k++) begin
         if (b_we && b_be[k]) mem[b_addr][8*k +: 8] <= b_wdata[8*k +: 8];
      end
      for (int k = 0; k < 4; k++) begin
         if (a_we && a_be[k]) mem[a_addr][8*k +: 8] <= a_wdata[8*k +: 8];
      end
   end

endmodule

// File: rtl/shared_wram_mapper.sv
module shared_wram_mapper
   import wram_map_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WIN_BYTES  = 8192,
   parameter int PAGE_BYTES = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [1:0]        mode_wdata,
   input  logic              a_rd,
   input  logic              a_wr,
   input  logic [1:0]        a_size,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [31:0]       a_wdata,
   output logic [31:0]       a_rdata,
   output logic              a_err,
   input  logic              b_rd,
   input  logic              b_wr,
   input  logic [1:0]        b_size,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [31:0]       b_wdata,
   output logic [31:0]       b_rdata,
   output logic              b_err
);

   localparam int WIN_AW  = $clog2(WIN_BYTES);
   localparam int PAGE_AW = $clog2(PAGE_BYTES);
   localparam int PG_W    = WIN_AW - PAGE_AW;
   localparam int WORDS   = WIN_BYTES / 4;
   localparam int WA      = WIN_AW - 2;

   if ((WIN_BYTES & (WIN_BYTES - 1)) != 0) begin : g_bad_win
      $error("WIN_BYTES must be a power of two");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 4) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 4");
   end
   if (WIN_BYTES < 2 * PAGE_BYTES) begin : g_bad_ratio
      $error("WIN_BYTES must hold at least two pages");
   end
   if (ADDR_W < WIN_AW) begin : g_bad_addr
      $error("ADDR_W narrower than the window");
   end

   map_mode_e mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MAP_A_ALL;
      end else if (mode_we) begin
         mode_q <= map_mode_e'(mode_wdata);
      end
   end

   logic [1:0]             rd_v, wr_v, we_v, re_v, err_v;
   logic [1:0][1:0]        size_v;
   logic [1:0][ADDR_W-1:0] addr_v;
   logic [1:0][31:0]       wd_v, rdat_v, mwd_v, rword_v;
   logic [1:0][WA-1:0]     maddr_v;
   logic [1:0][3:0]        be_v;

   assign rd_v   = {b_rd, a_rd};
   assign wr_v   = {b_wr, a_wr};
   assign size_v = {b_size, a_size};
   assign addr_v = {b_addr, a_addr};
   assign wd_v   = {b_wdata, a_wdata};

   for (genvar p = 0; p < 2; p++) begin : g_side
      wram_port #(
         .ADDR_W (ADDR_W),
         .WIN_AW (WIN_AW),
         .PAGE_AW(PAGE_AW),
         .SIDE_B (p == 1),
         .PG_W   (PG_W)
      ) i_port (
         .clk      (clk),
         .rst_n    (rst_n),
         .map_load (mode_we),
         .map_new  (map_mode_e'(mode_wdata)),
         .rd       (rd_v[p]),
         .wr       (wr_v[p]),
         .size     (size_v[p]),
         .addr     (addr_v[p]),
         .wdata    (wd_v[p]),
         .mem_rword(rword_v[p]),
         .mem_we   (we_v[p]),
         .mem_re   (re_v[p]),
         .mem_addr (maddr_v[p]),
         .mem_be   (be_v[p]),
         .mem_wdata(mwd_v[p]),
         .rdata    (rdat_v[p]),
         .err      (err_v[p])
      );
   end

   wram_store #(
      .WORDS(WORDS),
      .WA   (WA)
   ) i_store (
      .clk    (clk),
      .a_we   (we_v[0]),
      .a_re   (re_v[0]),
      .a_addr (maddr_v[0]),
      .a_be   (be_v[0]),
      .a_wdata(mwd_v[0]),
      .a_rword(rword_v[0]),
      .b_we   (we_v[1]),
      .b_re   (re_v[1]),
      .b_addr (maddr_v[1]),
      .b_be   (be_v[1]),
      .b_wdata(mwd_v[1]),
      .b_rword(rword_v[1])
   );

   assign a_rdata = rdat_v[0];
   assign a_err   = err_v[0];
   assign b_rdata = rdat_v[1];
   assign b_err   = err_v[1];

endmodule

// File: rtl/wram_mapper_checker.sv
module wram_mapper_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        mode_we,
   input logic [1:0]  mode_wdata,
   input logic [1:0]  mode_q,
   input logic        a_rd,
   input logic        a_wr,
   input logic [31:0] a_rdata,
   input logic        a_err,
   input logic        b_rd,
   input logic        b_wr,
   input logic [31:0] b_rdata,
   input logic        b_err
);

   assert_a_err_after_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      a_err |-> $past(a_rd || a_wr));
   assert_b_err_after_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      b_err |-> $past(b_rd || b_wr));

   assert_a_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      a_err |-> (a_rdata == 32'd0));
   assert_b_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      b_err |-> (b_rdata == 32'd0));

   assert_b_cut_off_mode0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 && (b_rd || b_wr)) |=> b_err);
   assert_a_cut_off_mode3_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b11 && (a_rd || a_wr)) |=> a_err);

   assert_split_a_no_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01 && (a_rd || a_wr || b_rd || b_wr)) |=> (!a_err && !b_err));
   assert_split_b_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b10 && (a_rd || a_wr || b_rd || b_wr)) |=> (!a_err && !b_err));

   assert_mode_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> (mode_q == $past(mode_wdata)));

   assert_a_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_rd && !a_wr) |=> (a_rdata == 32'd0));
   assert_b_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(b_rd && !b_wr) |=> (b_rdata == 32'd0));

endmodule

bind shared_wram_mapper wram_mapper_checker i_mapper_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode_we   (mode_we),
   .mode_wdata(mode_wdata),
   .mode_q    (mode_q),
   .a_rd      (a_rd),
   .a_wr      (a_wr),
   .a_rdata   (a_rdata),
   .a_err     (a_err),
   .b_rd      (b_rd),
   .b_wr      (b_wr),
   .b_rdata   (b_rdata),
   .b_err     (b_err)
);

// File: tb/test_shared_wram_mapper.sv
module test_shared_wram_mapper;

   localparam int CLK_PERIOD = 10;
   localparam int WIN        = 8192;
   localparam int HALF       = WIN / 2;

   typedef struct {
      bit          rd;
      bit          wr;
      logic [1:0]  sz;
      logic [31:0] ad;
      logic [31:0] wd;
   } op_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_we = 1'b0;
   logic [1:0]  mode_wdata = 2'b00;
   logic        a_rd = 1'b0, a_wr = 1'b0, b_rd = 1'b0, b_wr = 1'b0;
   logic [1:0]  a_size = 2'b10, b_size = 2'b10;
   logic [31:0] a_addr = '0, b_addr = '0, a_wdata = '0, b_wdata = '0;
   logic [31:0] a_rdata, b_rdata;
   logic        a_err, b_err;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shared_wram_mapper #(
      .ADDR_W    (32),
      .WIN_BYTES (WIN),
      .PAGE_BYTES(1024)
   ) i_shared_wram_mapper (
      .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
      .a_rd(a_rd), .a_wr(a_wr), .a_size(a_size), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .a_err(a_err),
      .b_rd(b_rd), .b_wr(b_wr), .b_size(b_size), .b_addr(b_addr), .b_wdata(b_wdata),
      .b_rdata(b_rdata), .b_err(b_err)
   );

   int         n_checks = 0;
   int         n_fail = 0;
   bit         done = 1'b0;
   logic [7:0] mdl [WIN];
   logic [1:0] mdl_mode = 2'b00;

   function automatic op_t mk(bit rd, bit wr, logic [1:0] sz, logic [31:0] ad, logic [31:0] wd);
      op_t o;
      o.rd = rd; o.wr = wr; o.sz = sz; o.ad = ad; o.wd = wd;
      return o;
   endfunction

   function automatic op_t idle();
      return mk(1'b0, 1'b0, 2'b10, 32'd0, 32'd0);
   endfunction

   function automatic int nbytes(logic [1:0] sz);
      return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
   endfunction

   // Physical byte address per the mapping requirements R1..R5, R7.
   function automatic int xlate(bit side_b, logic [1:0] md, logic [31:0] ad,
                                logic [1:0] sz, output bit hit);
      int m;
      m = int'(ad & 32'(WIN - 1));
      m = m & ~(nbytes(sz) - 1);
      case (md)
         2'b00: begin hit = !side_b; return m; end
         2'b01: begin hit = 1'b1; return side_b ? (m % HALF) : HALF + (m % HALF); end
         2'b10: begin hit = 1'b1; return side_b ? HALF + (m % HALF) : (m % HALF); end
         default: begin hit = side_b; return m; end
      endcase
   endfunction

   function automatic logic [31:0] mdl_read(int phys, logic [1:0] sz);
      logic [31:0] v;
      v = '0;
      for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = mdl[phys + k];
      return v;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic issue(string tag, bit mwe, logic [1:0] mwd, op_t oa, op_t ob);
      bit          ha, hb;
      int          pa, pb;
      logic [31:0] ea_d, eb_d;
      bit          ea_e, eb_e;
      mode_we = mwe; mode_wdata = mwd;
      a_rd = oa.rd; a_wr = oa.wr; a_size = oa.sz; a_addr = oa.ad; a_wdata = oa.wd;
      b_rd = ob.rd; b_wr = ob.wr; b_size = ob.sz; b_addr = ob.ad; b_wdata = ob.wd;
      pa = xlate(1'b0, mdl_mode, oa.ad, oa.sz, ha);
      pb = xlate(1'b1, mdl_mode, ob.ad, ob.sz, hb);
      ea_e = (oa.rd || oa.wr) && !ha;
      eb_e = (ob.rd || ob.wr) && !hb;
      ea_d = (oa.rd && !oa.wr && ha) ? mdl_read(pa, oa.sz) : 32'd0;
      eb_d = (ob.rd && !ob.wr && hb) ? mdl_read(pb, ob.sz) : 32'd0;
      if (ob.wr && hb) for (int k = 0; k < nbytes(ob.sz); k++) mdl[pb + k] = ob.wd[8*k +: 8];
      if (oa.wr && ha) for (int k = 0; k < nbytes(oa.sz); k++) mdl[pa + k] = oa.wd[8*k +: 8];
      if (mwe) mdl_mode = mwd;
      @(posedge clk);
      @(negedge clk);
      chk(tag, "a_rdata", a_rdata, ea_d);
      chk(tag, "a_err", {31'd0, a_err}, {31'd0, ea_e});
      chk(tag, "b_rdata", b_rdata, eb_d);
      chk(tag, "b_err", {31'd0, b_err}, {31'd0, eb_e});
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed_val;
      seed_val = $urandom(32'd4711);
      for (int i = 0; i < WIN; i++) mdl[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset: outputs quiet, mode is 00
      chk("R8 reset", "a_rdata", a_rdata, 32'd0);
      chk("R8 reset", "a_err", {31'd0, a_err}, 32'd0);
      chk("R8 reset", "b_err", {31'd0, b_err}, 32'd0);

      // R2 fill the whole window from side A in mode 00
      for (int w = 0; w < WIN / 4; w++)
         issue("R2 fill", 1'b0, 2'b00, mk(1'b0, 1'b1, 2'b10, 32'(w * 4), 32'(w) * 32'h01010101 ^ 32'hC0DE0000), idle());

      // R1 high address bits ignored
      issue("R1", 1'b0, 2'b00, mk(1'b0, 1'b1, 2'b10, 32'hFFFF_E010, 32'hA1B2C3D4), idle());
      issue("R1", 1'b0, 2'b00, mk(1'b1, 1'b0, 2'b10, 32'h0000_0010, 32'd0), idle());
      // R2 side B cut off in mode 00
      issue("R2", 1'b0, 2'b00, idle(), mk(1'b1, 1'b0, 2'b10, 32'h10, 32'd0));
      // R7 byte write at odd address, word/half reads with alignment
      issue("R7", 1'b0, 2'b00, mk(1'b0, 1'b1, 2'b00, 32'h13, 32'hFFFF_FF5A), idle());
      issue("R7", 1'b0, 2'b00, mk(1'b1, 1'b0, 2'b10, 32'h12, 32'd0), idle());
      issue("R7", 1'b0, 2'b00, mk(1'b1, 1'b0, 2'b01, 32'h13, 32'd0), idle());
      issue("R7", 1'b0, 2'b00, mk(1'b1, 1'b0, 2'b00, 32'h11, 32'd0), idle());
      issue("R7", 1'b0, 2'b00, mk(1'b0, 1'b1, 2'b01, 32'h17, 32'hDEAD_7E57), idle());
      issue("R7", 1'b0, 2'b00, mk(1'b1, 1'b0, 2'b11, 32'h14, 32'd0), idle());
      // R8 load mode 01 while both sides access: old mapping applies
      issue("R8", 1'b1, 2'b01, mk(1'b1, 1'b0, 2'b10, 32'h10, 32'd0), mk(1'b1, 1'b0, 2'b10, 32'h10, 32'd0));
      // R3 split mapping and mirroring
      issue("R3", 1'b0, 2'b00, mk(1'b0, 1'b1, 2'b10, 32'h0, 32'h11223344), mk(1'b1, 1'b0, 2'b10, 32'h10, 32'd0));
      issue("R3", 1'b0, 2'b00, mk(1'b1, 1'b0, 2'b10, 32'(HALF), 32'd0), mk(1'b1, 1'b0, 2'b10, 32'(HALF + 16), 32'd0));
      // R4 swapped halves
      issue("R4", 1'b1, 2'b10, idle(), idle());
      issue("R4", 1'b0, 2'b00, mk(1'b1, 1'b0, 2'b10, 32'h10, 32'd0), mk(1'b1, 1'b0, 2'b10, 32'h0, 32'd0));
      // R5 side A cut off in mode 11; R6 write discarded
      issue("R5", 1'b1, 2'b11, idle(), idle());
      issue("R6", 1'b0, 2'b00, mk(1'b0, 1'b1, 2'b10, 32'h20, 32'hBADB_AD00), mk(1'b1, 1'b0, 2'b10, 32'h20, 32'd0));
      issue("R5", 1'b0, 2'b00, mk(1'b1, 1'b0, 2'b10, 32'h20, 32'd0), mk(1'b1, 1'b0, 2'b10, 32'h20, 32'd0));
      issue("R6", 1'b0, 2'b00, idle(), idle());
      // R10 read and write together on one side
      issue("R10", 1'b0, 2'b00, idle(), mk(1'b1, 1'b1, 2'b10, 32'h24, 32'h0F0E_0D0C));
      issue("R10", 1'b0, 2'b00, idle(), mk(1'b1, 1'b0, 2'b10, 32'h24, 32'd0));
      // R9 read-before-write on one side in consecutive cycles
      issue("R9", 1'b0, 2'b00, idle(), mk(1'b1, 1'b0, 2'b10, 32'h24, 32'd0));

      // R9 constrained random traffic with occasional mode loads
      for (int n = 0; n < 4000; n++) begin
         op_t         oa, ob;
         logic [31:0] ra, rb;
         ra = ($urandom % 2 == 0) ? $urandom : ($urandom & 32'hF000_003F) | 32'(HALF * ($urandom % 2));
         rb = ($urandom % 2 == 0) ? $urandom : ($urandom & 32'hF000_003F) | 32'(HALF * ($urandom % 2));
         oa = mk(1'($urandom), 1'($urandom % 3 == 0), 2'($urandom), ra, $urandom);
         ob = mk(1'($urandom), 1'($urandom % 3 == 0), 2'($urandom), rb, $urandom);
         issue("R9 random", ($urandom % 16) == 0, 2'($urandom), oa, ob);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule